// File: doc/BRIEF.md
# Microcode Program Counter Sequencer

This block holds the address of the microinstruction being executed and works out the next one. Each cycle a two-bit source code picks one of four candidates for the next address. The candidates are the entry address from the instruction decoder table, the current address plus one, a staged branch target, and zero. The register takes the chosen value only on a cycle where its load enable is high.

Branching takes two steps. First a microinstruction writes the target into a dedicated jump register. A later microinstruction raises the branch strobe together with the test result. While the strobe is high, the test result overrides the source code. A true result takes the staged target, and a false result falls through to the next sequential address. The jump register keeps its value until it is written again, so a loop can branch back to the same target many times without reloading it.

The microcode ROM contents and the decoding of microinstruction fields belong to the surrounding controller.

Top module: `upc_sequencer`

## Requirements
- R1: While `rst_n` is low, `upc` reads 0x0000 and the jump register is cleared to 0x0000. A taken branch straight after reset therefore goes to 0x0000.
- R2: On a clock edge where `pc_le` is low, `upc` keeps its value, whatever the other inputs are.
- R3: With `pc_le` high, `branch_en` low and `src_sel` = 2'b00, `upc` becomes the old value plus one, and 0xFFFF wraps to 0x0000.
- R4: With `pc_le` high, `branch_en` low and `src_sel` = 2'b01, `upc` becomes `dec_addr`.
- R5: With `pc_le` high, `branch_en` low and `src_sel` = 2'b10, `upc` becomes the jump register value.
- R6: With `pc_le` high, `branch_en` low and `src_sel` = 2'b11, `upc` becomes 0x0000.
- R7: The jump register takes `jreg_data` on an edge where `jreg_load` is high, and keeps its value on every other edge.
- R8: With `pc_le` and `branch_en` high and `branch_cond` high, `upc` becomes the jump register value, whatever `src_sel` holds.
- R9: With `pc_le` and `branch_en` high and `branch_cond` low, `upc` becomes the old value plus one, whatever `src_sel` holds.
- R10: A branch taken in the same cycle that the jump register is written uses the old target. The new target applies from the next cycle on.
- R11: A branch strobe on a cycle where `pc_le` is low leaves `upc` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pc_le | input | 1 | Load enable for the microcode PC |
| src_sel | input | 2 | Next-address source: 00 increment, 01 decoder, 10 jump register, 11 zero |
| dec_addr | input | ADDR_W | Routine entry address from the instruction decoder table |
| jreg_load | input | 1 | Write strobe for the jump register |
| jreg_data | input | ADDR_W | Branch target to stage in the jump register |
| branch_en | input | 1 | A conditional branch is being resolved this cycle |
| branch_cond | input | 1 | Result of the branch test |
| upc | output | ADDR_W | Current microcode PC |

## Verification
Each source code is applied while `dec_addr` and the jump register hold distinct values. This shows whether a wrong mux leg is selected. Long runs of increments end in a decoder load of 0xFFFF, which exposes a missing wrap. Branches are driven with `src_sel` set to each non-matching code, so a branch that fails to override the code shows up, and in separate steps with `pc_le` low, so a branch that ignores the enable shows up. The same-cycle write-and-branch case, and a repeat branch with no reload, separate an old staged target from a new one. A pseudo-random stretch mixes all inputs, and every cycle is compared against a behavioural model.

// File: rtl/upc_pkg.sv
package upc_pkg;

    // Next-address source codes; the two-bit value is the src_sel input.
    typedef enum logic [1:0] {
        SRC_INC    = 2'b00,
        SRC_DECODE = 2'b01,
        SRC_JUMP   = 2'b10,
        SRC_ZERO   = 2'b11
    } upc_src_e;

endpackage

// File: rtl/upc_jump_reg.sv
module upc_jump_reg #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] data,
    output logic [ADDR_W-1:0] target
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            target <= '0;
        end else if (load) begin
            target <= data;
        end
    end

    // R7: a write takes the presented data
    p_jreg_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> target == $past(data));

    // R7: no write, no change
    p_jreg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(target));

endmodule

// File: rtl/upc_incr.sv
module upc_incr #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] cur,
    output logic [ADDR_W-1:0] nxt
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

    // Modular add: the all-ones address wraps to zero (R3)
    always_comb begin
        nxt = cur + STEP;
    end

endmodule

// File: rtl/upc_next_sel.sv
module upc_next_sel
    import upc_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [1:0]        src_sel,
    input  logic              branch_en,
    input  logic              branch_cond,
    input  logic [ADDR_W-1:0] dec_addr,
    input  logic [ADDR_W-1:0] jump_target,
    input  logic [ADDR_W-1:0] inc_addr,
    output upc_src_e          eff_src,
    output logic [ADDR_W-1:0] next_addr
);

    // The branch test overrides the coded source (R8, R9)
    always_comb begin
        if (branch_en) begin
            eff_src = branch_cond ? SRC_JUMP : SRC_INC;
        end else begin
            eff_src = upc_src_e'(src_sel);
        end
    end

    always_comb begin
        unique case (eff_src)
            SRC_INC:    next_addr = inc_addr;
            SRC_DECODE: next_addr = dec_addr;
            SRC_JUMP:   next_addr = jump_target;
            SRC_ZERO:   next_addr = '0;
            default:    next_addr = '0;
        endcase
    end

    // A branch never resolves to the decoder or zero leg
    always_comb begin
        if (branch_en) begin
            a_branch_leg_r8: assert (eff_src == SRC_JUMP || eff_src == SRC_INC);
        end
    end

endmodule

// File: rtl/upc_sequencer.sv
module upc_sequencer
    import upc_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pc_le,
    input  logic [1:0]        src_sel,
    input  logic [ADDR_W-1:0] dec_addr,
    input  logic              jreg_load,
    input  logic [ADDR_W-1:0] jreg_data,
    input  logic              branch_en,
    input  logic              branch_cond,
    output logic [ADDR_W-1:0] upc
);

    logic [ADDR_W-1:0] jump_q;
    logic [ADDR_W-1:0] inc_addr;
    logic [ADDR_W-1:0] next_addr;
    upc_src_e          eff_src;

    upc_jump_reg #(.ADDR_W(ADDR_W)) jump_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (jreg_load),
        .data   (jreg_data),
        .target (jump_q)
    );

    upc_incr #(.ADDR_W(ADDR_W)) incr_i (
        .cur (upc),
        .nxt (inc_addr)
    );

    upc_next_sel #(.ADDR_W(ADDR_W)) sel_i (
        .src_sel     (src_sel),
        .branch_en   (branch_en),
        .branch_cond (branch_cond),
        .dec_addr    (dec_addr),
        .jump_target (jump_q),
        .inc_addr    (inc_addr),
        .eff_src     (eff_src),
        .next_addr   (next_addr)
    );

    // PC register: reset to zero, load only when enabled
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upc <= '0;
        end else if (pc_le) begin
            upc <= next_addr;
        end
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_le |=> $stable(upc));

    p_incr_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_le && !branch_en && src_sel == 2'b00) |=> upc == $past(upc) + ADDR_W'(1));

    p_decode_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_le && !branch_en && src_sel == 2'b01) |=> upc == $past(dec_addr));

    p_jump_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_le && !branch_en && src_sel == 2'b10) |=> upc == $past(jump_q));

    p_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_le && !branch_en && src_sel == 2'b11) |=> upc == '0);

    // R10: the target used is the one held before this edge
    p_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_le && branch_en && branch_cond) |=> upc == $past(jump_q));

    p_not_taken_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_le && branch_en && !branch_cond) |=> upc == $past(upc) + ADDR_W'(1));

endmodule

// File: tb/upc_sequencer_tb_top.sv
module upc_sequencer_tb_top;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pc_le = 1'b0;
    logic [1:0]    src_sel = 2'b00;
    logic [AW-1:0] dec_addr = '0;
    logic          jreg_load = 1'b0;
    logic [AW-1:0] jreg_data = '0;
    logic          branch_en = 1'b0;
    logic          branch_cond = 1'b0;
    logic [AW-1:0] upc;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    upc_sequencer #(.ADDR_W(AW)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pc_le       (pc_le),
        .src_sel     (src_sel),
        .dec_addr    (dec_addr),
        .jreg_load   (jreg_load),
        .jreg_data   (jreg_data),
        .branch_en   (branch_en),
        .branch_cond (branch_cond),
        .upc         (upc)
    );

    // Behavioural reference model, integer based
    int m_pc = 0;
    int m_tgt = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pc = 0;
            m_tgt = 0;
        end else begin
            int nxt;
            nxt = m_pc;
            if (pc_le) begin
                if (branch_en) nxt = branch_cond ? m_tgt : (m_pc + 1) % 65536;
                else if (src_sel == 2'd0) nxt = (m_pc + 1) % 65536;
                else if (src_sel == 2'd1) nxt = int'(dec_addr);
                else if (src_sel == 2'd2) nxt = m_tgt;
                else nxt = 0;
            end
            if (jreg_load) m_tgt = int'(jreg_data);
            m_pc = nxt;
        end
    end

    task automatic check(input string tag, input int expv);
        checks++;
        if (int'(upc) != expv) begin
            failures++;
            $display("FAIL %s: upc actual=%h expected=%h", tag, upc, expv[15:0]);
        end
    endtask

    task automatic step(input string tag, input bit le, input logic [1:0] sel,
                        input bit ben, input bit bc, input bit jl,
                        input logic [AW-1:0] jd, input logic [AW-1:0] da);
        pc_le = le; src_sel = sel; branch_en = ben; branch_cond = bc;
        jreg_load = jl; jreg_data = jd; dec_addr = da;
        @(posedge clk);
        #1;
        check(tag, m_pc);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog: actual=%0d cycles expected=finish", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        #1;
        check("R1 reset", 0);
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset held", 0);
        rst_n = 1'b1;
        // R3 sequential stepping
        for (int i = 0; i < 4; i++) step("R3 incr", 1, 2'b00, 0, 0, 0, 16'h0000, 16'h0777);
        check("R3 count", 4);
        // R1 jump register cleared by reset: taken branch goes to zero
        step("R1 jreg clear", 1, 2'b01, 1, 1, 0, 16'h0000, 16'h0777);
        check("R1 jreg zero", 0);
        // R4 decoder entry
        step("R4 decode", 1, 2'b01, 0, 0, 0, 16'h0000, 16'h1234);
        check("R4 decode value", 16'h1234);
        // R2 hold with every code and varying inputs
        for (int s = 0; s < 4; s++) step("R2 hold", 0, 2'(s), 0, 0, 0, 16'h0000, 16'h4321);
        check("R2 held value", 16'h1234);
        // R7 stage target with pc_le low, then R5 select it
        step("R7 jreg write", 0, 2'b00, 0, 0, 1, 16'hABCD, 16'h0000);
        step("R7 jreg keep", 0, 2'b00, 0, 0, 0, 16'h1111, 16'h0000);
        step("R5 jump select", 1, 2'b10, 0, 0, 0, 16'h2222, 16'h0000);
        check("R5 jump value", 16'hABCD);
        // R6 zero
        step("R6 zero", 1, 2'b11, 0, 0, 0, 16'h0000, 16'h5A5A);
        check("R6 zero value", 0);
        // R3 wrap
        step("R4 decode top", 1, 2'b01, 0, 0, 0, 16'h0000, 16'hFFFF);
        step("R3 wrap", 1, 2'b00, 0, 0, 0, 16'h0000, 16'h0000);
        check("R3 wrap value", 0);
        // R8 taken branch overriding decoder and zero codes
        step("R8 taken over decode", 1, 2'b01, 1, 1, 0, 16'h0000, 16'h0F0F);
        check("R8 taken value", 16'hABCD);
        step("R8 taken over zero", 1, 2'b11, 1, 1, 0, 16'h0000, 16'h0F0F);
        // R9 not taken overriding jump and zero codes
        step("R9 not taken over zero", 1, 2'b11, 1, 0, 0, 16'h0000, 16'h0F0F);
        check("R9 fallthrough value", 16'hABCE);
        step("R9 not taken over jump", 1, 2'b10, 1, 0, 0, 16'h0000, 16'h0F0F);
        check("R9 fallthrough 2", 16'hABCF);
        // R10 write and branch in one cycle use old target
        step("R10 same cycle", 1, 2'b00, 1, 1, 1, 16'h5555, 16'h0000);
        check("R10 old target", 16'hABCD);
        step("R10 new target", 1, 2'b00, 1, 1, 0, 16'h0000, 16'h0000);
        check("R10 new target value", 16'h5555);
        step("R9 step", 1, 2'b00, 1, 0, 0, 16'h0000, 16'h0000);
        step("R10 repeat no reload", 1, 2'b00, 1, 1, 0, 16'h0000, 16'h0000);
        check("R10 repeat value", 16'h5555);
        // R11 branch without enable
        step("R11 branch no le", 0, 2'b01, 1, 1, 0, 16'h0000, 16'h7777);
        step("R11 nottaken no le", 0, 2'b11, 1, 0, 0, 16'h0000, 16'h7777);
        check("R11 held", 16'h5555);
        // Mixed pseudo-random stretch
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step("mix", lfsr[0], lfsr[2:1], lfsr[3] & lfsr[4], lfsr[5], lfsr[6],
                 {lfsr[7:0], lfsr[15:8]}, lfsr ^ 16'h3C3C);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule